// File: doc/BRIEF.md
# Shared Interrupt Pin and Processor Router

This block takes a vector of already-conditioned shared interrupt levels and steers each one to a set of virtual processors. For each interrupt, the block can drive one numbered pin of those processors, their non-maskable line, or both. Every interrupt has two configuration words. The pin-map word holds two routing enables and a pin number. The processor-map word holds a bitmap of the target processors.

All interrupts that land on the same processor and pin are OR-combined into that processor's pin vector. All interrupts that request the non-maskable path on a processor are OR-combined into its NMI line. Both output sets are registered.

Configuration arrives over a plain single-cycle write strobe with a byte address and a 32-bit data word. There is no read path. Interrupt inputs and routed outputs are level signals, not streams, so neither side carries a valid/ready handshake and the block never applies back-pressure.

Top module: `irq_pin_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are 0. Reset clears every map word, so asserted interrupts route nowhere until the words are written again.
- R2: A write with `cfg_addr[ADDR_W-1]`=0 and `cfg_addr[1:0]`=0 loads the pin-map word of interrupt `cfg_addr[ADDR_W-2:2]` (stride 4 bytes). In that word, bit 31 enables pin routing, bit 30 enables NMI routing, and bits 5:0 give the pin number. All other bits are ignored.
- R3: A write with `cfg_addr[ADDR_W-1]`=1 and `cfg_addr[4:0]`=0 loads the processor bitmap of interrupt `cfg_addr[ADDR_W-2:5]` (stride 32 bytes) from `cfg_wdata[NUM_VP-1:0]`, where bit v selects processor v. Writes elsewhere in a 32-byte slot, and pin-region writes with nonzero `cfg_addr[1:0]`, change nothing.
- R4: An asserted interrupt whose pin enable is set, and whose pin number p is below NUM_PIN, drives `vp_pin_o[v*NUM_PIN+p]` high for every processor v in its bitmap.
- R5: An asserted interrupt whose NMI enable is set drives `vp_nmi_o[v]` high for every processor v in its bitmap. With both enables set, it drives both the pin and the NMI line.
- R6: An interrupt with neither enable set drives no output, whatever its bitmap.
- R7: A pin number of NUM_PIN or more is ignored for pin routing. The NMI routing of the same interrupt still applies.
- R8: When several asserted interrupts map to the same processor and pin, or to the same NMI line, the output is their OR.
- R9: Outputs are registered. The value after a clock edge reflects the interrupt inputs and the map words as they were just before that edge. A configuration write therefore shows at the outputs one edge after the edge that stores it.
- R10: Writes to an interrupt index of NUM_IRQ or more change no map word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | NUM_IRQ | Conditioned shared interrupt levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| vp_pin_o | output | NUM_VP*NUM_PIN | Pin vectors, processor v in bits v*NUM_PIN +: NUM_PIN |
| vp_nmi_o | output | NUM_VP | Non-maskable line per processor |

## Verification
The bench builds the router with six interrupts, three processors and five pins. Because the pin count is not a power of two, pin numbers 5 through 63 are reachable as out-of-range values. Because the interrupt count leaves unused indices below the address limit, indices 6 and up are reachable as ignored writes. A behavioural model built on plain integer arrays predicts both output vectors on every clock. Directed phases cover each routing flavour, aliasing of misaligned addresses, and a reset that arrives mid-run. A random phase then mixes writes with changing interrupt levels.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int PIN_FIELD_W    = 6;
  localparam int PIN_EN_BIT     = 31;
  localparam int NMI_EN_BIT     = 30;
  localparam int PMAP_STRIDE_LG = 2;   // 4-byte stride
  localparam int VMAP_STRIDE_LG = 5;   // 32-byte stride

  typedef struct packed {
    logic                   to_pin;
    logic                   to_nmi;
    logic [PIN_FIELD_W-1:0] pin;
  } pin_map_t;
endpackage

// File: rtl/rt_map_regs.sv
module rt_map_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_VP  = 4,
  parameter int ADDR_W  = 13
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [31:0]                       wdata,
  output pin_map_t [NUM_IRQ-1:0]            pmap_o,
  output logic [NUM_IRQ-1:0][NUM_VP-1:0]    vmap_o
);
  localparam int REGION_BIT = ADDR_W - 1;
  localparam int PIDX_W     = REGION_BIT - PMAP_STRIDE_LG;
  localparam int VIDX_W     = REGION_BIT - VMAP_STRIDE_LG;

  logic [PIDX_W-1:0] pidx;
  logic [VIDX_W-1:0] vidx;
  logic              pin_region_wr;
  logic              vp_region_wr;

  assign pidx = addr[REGION_BIT-1:PMAP_STRIDE_LG];
  assign vidx = addr[REGION_BIT-1:VMAP_STRIDE_LG];
  assign pin_region_wr = we && !addr[REGION_BIT] &&
                         (addr[PMAP_STRIDE_LG-1:0] == '0);
  assign vp_region_wr  = we && addr[REGION_BIT] &&
                         (addr[VMAP_STRIDE_LG-1:0] == '0);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        pmap_o[i] <= '0;
        vmap_o[i] <= '0;
      end else begin
        if (pin_region_wr && (pidx == PIDX_W'(i))) begin
          pmap_o[i].to_pin <= wdata[PIN_EN_BIT];
          pmap_o[i].to_nmi <= wdata[NMI_EN_BIT];
          pmap_o[i].pin    <= wdata[PIN_FIELD_W-1:0];
        end
        if (vp_region_wr && (vidx == VIDX_W'(i)))
          vmap_o[i] <= wdata[NUM_VP-1:0];
      end
    end
  end
endmodule

// File: rtl/rt_route_matrix.sv
module rt_route_matrix
  import irq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic [NUM_IRQ-1:0]             irq,
  input  pin_map_t [NUM_IRQ-1:0]         pmap,
  input  logic [NUM_IRQ-1:0][NUM_VP-1:0] vmap,
  output logic [NUM_VP*NUM_PIN-1:0]      pin_vec,
  output logic [NUM_VP-1:0]              nmi_vec
);
  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    logic [NUM_IRQ-1:0] nmi_hit;
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_nmi
      assign nmi_hit[i] = irq[i] & vmap[i][v] & pmap[i].to_nmi;
    end
    assign nmi_vec[v] = |nmi_hit;

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic [NUM_IRQ-1:0] pin_hit;
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        assign pin_hit[i] = irq[i] & vmap[i][v] & pmap[i].to_pin &
                            (pmap[i].pin == PIN_FIELD_W'(p));
      end
      assign pin_vec[v*NUM_PIN+p] = |pin_hit;
    end
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_router_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int ADDR_W  = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [NUM_VP*NUM_PIN-1:0] vp_pin_o,
  output logic [NUM_VP-1:0]         vp_nmi_o
);
  localparam int OUT_W = NUM_VP * NUM_PIN;

  pin_map_t [NUM_IRQ-1:0]         pmap;
  logic [NUM_IRQ-1:0][NUM_VP-1:0] vmap;
  logic [OUT_W-1:0]               pin_next;
  logic [NUM_VP-1:0]              nmi_next;

  rt_map_regs #(.NUM_IRQ(NUM_IRQ), .NUM_VP(NUM_VP), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .pmap_o (pmap),
    .vmap_o (vmap)
  );

  rt_route_matrix #(.NUM_IRQ(NUM_IRQ), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_matrix (
    .irq     (irq_i),
    .pmap    (pmap),
    .vmap    (vmap),
    .pin_vec (pin_next),
    .nmi_vec (nmi_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_pin_o <= '0;
      vp_nmi_o <= '0;
    end else begin
      vp_pin_o <= pin_next;
      vp_nmi_o <= nmi_next;
    end
  end
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int ADDR_W  = 13
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_IRQ-1:0]        irq_i,
  input logic                      cfg_we,
  input logic [NUM_VP*NUM_PIN-1:0] vp_pin_o,
  input logic [NUM_VP-1:0]         vp_nmi_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vp_pin_o == '0 && vp_nmi_o == '0));

  // R6
  no_source_no_route_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_i == '0) |=> (vp_pin_o == '0 && vp_nmi_o == '0));

  // R9
  output_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (vp_pin_o != '0 || vp_nmi_o != '0) |-> ($past(irq_i) != '0));

  // R9
  steady_inputs_steady_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !$past(cfg_we) && $stable(irq_i)) |=>
      ($stable(vp_pin_o) && $stable(vp_nmi_o)));
endmodule

bind irq_pin_router irq_pin_router_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_i    (irq_i),
  .cfg_we   (cfg_we),
  .vp_pin_o (vp_pin_o),
  .vp_nmi_o (vp_nmi_o)
);

// File: tb/irq_pin_router_tb.sv
module irq_pin_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 6;
  localparam int NV = 3;
  localparam int NP = 5;
  localparam int AW = 13;
  localparam int WATCHDOG = 20000;

  logic clk = 0;
  logic rst = 1;
  logic [NI-1:0]    irq_i = '0;
  logic             cfg_we = 0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [NV*NP-1:0] vp_pin_o;
  logic [NV-1:0]    vp_nmi_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_router #(.NUM_IRQ(NI), .NUM_VP(NV), .NUM_PIN(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .vp_pin_o(vp_pin_o), .vp_nmi_o(vp_nmi_o)
  );

  // reference model
  int m_pin_en [NI];
  int m_nmi_en [NI];
  int m_pin    [NI];
  int m_vps    [NI];
  logic [NV*NP-1:0] exp_pin = '0;
  logic [NV-1:0]    exp_nmi = '0;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < NI; i++) begin
        m_pin_en[i] = 0; m_nmi_en[i] = 0; m_pin[i] = 0; m_vps[i] = 0;
      end
      exp_pin = '0;
      exp_nmi = '0;
    end else begin
      exp_pin = '0;
      exp_nmi = '0;
      for (int i = 0; i < NI; i++)
        if (irq_i[i])
          for (int v = 0; v < NV; v++)
            if (((m_vps[i] >> v) & 1) == 1) begin
              if (m_pin_en[i] != 0 && m_pin[i] < NP) exp_pin[v*NP + m_pin[i]] = 1'b1;
              if (m_nmi_en[i] != 0) exp_nmi[v] = 1'b1;
            end
      if (cfg_we) begin
        int a;
        a = int'(cfg_addr);
        if (a < 'h1000) begin
          if (a % 4 == 0 && a / 4 < NI) begin
            m_pin_en[a/4] = int'(cfg_wdata[31]);
            m_nmi_en[a/4] = int'(cfg_wdata[30]);
            m_pin[a/4]    = int'(cfg_wdata[5:0]);
          end
        end else begin
          a = a - 'h1000;
          if (a % 32 == 0 && a / 32 < NI) m_vps[a/32] = int'(cfg_wdata[NV-1:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (vp_pin_o !== exp_pin || vp_nmi_o !== exp_nmi) begin
        mismatched++;
        $display("FAIL %s: pin=%h nmi=%h expected pin=%h nmi=%h",
                 cur_req, vp_pin_o, vp_nmi_o, exp_pin, exp_nmi);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] pinw(input bit en_pin, input bit en_nmi, input int pin);
    return {en_pin, en_nmi, 24'b0, 6'(pin)};
  endfunction
  function automatic logic [AW-1:0] pa(input int i);
    return AW'(i * 4);
  endfunction
  function automatic logic [AW-1:0] va(input int i);
    return AW'('h1000 + i * 32);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_irq(input logic [NI-1:0] v, input string tag);
    @(negedge clk);
    cur_req = tag;
    irq_i = v;
  endtask

  initial begin
    // R1: reset state, irqs high but maps cleared
    irq_i = '1;
    idle(4);
    rst = 0;
    idle(3);
    set_irq('0, "R2");
    // R2 / R4: irq0 -> pin 2 of processors 0 and 2
    wr(pa(0), pinw(1, 0, 2));
    wr(va(0), 32'b101);
    set_irq(6'b000001, "R4");
    idle(3);
    // R5: irq1 NMI only on processor 1; irq2 both pin 4 and NMI on processor 0
    wr(pa(1), pinw(0, 1, 0));
    wr(va(1), 32'b010);
    set_irq(6'b000011, "R5");
    idle(2);
    wr(pa(2), pinw(1, 1, 4));
    wr(va(2), 32'b001);
    set_irq(6'b000111, "R5");
    idle(3);
    // R6: neither enable
    wr(pa(3), pinw(0, 0, 1));
    wr(va(3), 32'b111);
    set_irq(6'b001000, "R6");
    idle(3);
    // R7: out-of-range pin, NMI still routed
    wr(pa(4), pinw(1, 1, 7));
    wr(va(4), 32'b110);
    set_irq(6'b010000, "R7");
    idle(2);
    wr(pa(4), pinw(1, 0, 63));
    idle(3);
    // R8: OR of irq0 and irq5 on pin 2
    wr(pa(5), pinw(1, 0, 2));
    wr(va(5), 32'b011);
    set_irq(6'b100001, "R8");
    idle(2);
    set_irq(6'b100000, "R8");
    idle(2);
    set_irq(6'b000001, "R8");
    idle(2);
    // R3: misaligned writes leave irq3 bitmap empty
    set_irq(6'b001000, "R3");
    wr(pa(3), pinw(1, 0, 1));
    wr(va(3), 32'b0);
    wr(va(3) + 4, 32'hFFFF_FFFF);
    wr(va(3) + 1, 32'hFFFF_FFFF);
    wr(pa(3) + 2, pinw(1, 1, 0));
    idle(3);
    // R10: out-of-range indices
    set_irq(6'b111111, "R10");
    wr(va(6), 32'hFFFF_FFFF);
    wr(va(7), 32'hFFFF_FFFF);
    wr(pa(6), pinw(1, 1, 0));
    wr(pa(60), pinw(1, 1, 3));
    idle(3);
    // R9: random mix of writes and levels, one-cycle latency
    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      irq_i = NI'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1;
        cfg_addr = ($urandom_range(0, 1) == 0) ? pa($urandom_range(0, NI))
                                               : va($urandom_range(0, NI));
        cfg_wdata = $urandom;
      end else begin
        cfg_we = 0;
      end
    end
    @(negedge clk);
    cfg_we = 0;
    // R1: reset mid-run clears maps
    cur_req = "R1";
    rst = 1;
    idle(2);
    rst = 0;
    irq_i = '1;
    idle(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule